// File: doc/BRIEF.md
# Insertion Sorting Cell Array

This block puts one frame of time values into ascending order. The times arrive one per cycle during a frame, and each time carries a small hit-count tag. Every value enters a linear chain of cells and moves one cell per clock. As it goes, it carries a rank that grows by one for each occupied cell whose stored value does not exceed it. The first empty cell it reaches keeps the value together with the rank carried so far. An occupied cell whose stored value is larger than a passing value adds one to its own stored rank. When the chain is full, new input is refused.

A pulse on `frame_end` closes the frame. The block lets the values still in flight settle. It then shifts the chain toward its head, one cell per cycle, and writes each value into a small RAM at the address equal to its rank, counting the entries as they go. The RAM is then read from address 0 upward, one word per cycle, which yields the frame in ascending order with the final word flagged. The block takes no new input until that readout has finished.

Top module: `insort_array`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `out_last` are 0.
- R2: After a frame closes, its entries leave on `out_time` one per cycle in nondecreasing order of time.
- R3: Entries with equal times leave in the order in which they were accepted.
- R4: Each `out_hits` value appears in the same beat as the time it was accepted with.
- R5: A frame produces exactly as many `out_valid` beats as entries were accepted for it, and `out_last` is high on the final beat only.
- R6: A `frame_end` that the block acts on drops `in_ready` in the next cycle. `in_ready` stays low until the cycle after the `out_last` beat and then rises again. Any `in_valid` seen while `in_ready` is low is ignored.
- R7: A frame holds at most N_CELLS entries (default 32). `in_ready` falls once that many have been accepted, and further `in_valid` beats are ignored. A `frame_end` is still acted on while the chain is full.
- R8: A frame closed with no entries produces no `out_valid` beat, and `in_ready` is high again within 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An entry is offered on in_time/in_hits |
| in_time | input | TIME_W (16) | Time value to be ranked |
| in_hits | input | HITS_W (4) | Hit-count tag that travels with the time |
| frame_end | input | 1 | Closes the frame; acted on while the block is gathering entries |
| in_ready | output | 1 | High when an offered entry will be taken |
| out_valid | output | 1 | A sorted entry is on out_time/out_hits |
| out_time | output | TIME_W (16) | Sorted time |
| out_hits | output | HITS_W (4) | Hit-count tag of that time |
| out_last | output | 1 | Marks the final entry of the frame |

## Verification
A wrong rank in any cell becomes visible only at readout. Two entries written to the same address leave one RAM word stale, so readout shows either a value out of order or a value from an earlier frame. A compare that favours the wrong side on a tie shows up as swapped hit tags among equal times. These faults appear within the frame that caused them, one beat after the affected address is read. A miscount in the unload counter moves `out_last` or changes the number of beats. A sequencing fault shows up as `in_ready` rising too early or never rising. Because of this, the bench runs several frames back to back with different orderings, ties, an empty frame and a full one, and compares every beat.

// File: rtl/insort_pkg.sv
package insort_pkg;

  typedef enum logic [2:0] {
    PH_FILL   = 3'd0,
    PH_DRAIN  = 3'd1,
    PH_UNLOAD = 3'd2,
    PH_READ   = 3'd3,
    PH_TAIL   = 3'd4
  } phase_e;

  // An incoming value ranks after a stored one when it is not smaller;
  // ties therefore keep arrival order.
  function automatic logic ranks_after(input logic [63:0] incoming,
                                       input logic [63:0] stored);
    return incoming >= stored;
  endfunction

  function automatic logic [63:0] step_pos(input logic [63:0] pos,
                                           input logic inc);
    return pos + {63'd0, inc};
  endfunction

endpackage

// File: rtl/insort_cell.sv
module insort_cell
  import insort_pkg::*;
#(
  parameter int N_CELLS = 32,
  parameter int TIME_W  = 16,
  parameter int HITS_W  = 4,
  parameter int POS_W   = $clog2(N_CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              in_v,
  input  logic [TIME_W-1:0] in_t,
  input  logic [HITS_W-1:0] in_h,
  input  logic [POS_W-1:0]  in_p,
  output logic              fwd_v,
  output logic [TIME_W-1:0] fwd_t,
  output logic [HITS_W-1:0] fwd_h,
  output logic [POS_W-1:0]  fwd_p,
  input  logic              nxt_occ,
  input  logic [TIME_W-1:0] nxt_t,
  input  logic [HITS_W-1:0] nxt_h,
  input  logic [POS_W-1:0]  nxt_p,
  output logic              occ,
  output logic [TIME_W-1:0] st_t,
  output logic [HITS_W-1:0] st_h,
  output logic [POS_W-1:0]  st_p,
  output logic              take_ev,
  output logic              bump_ev
);

  logic goes_after;

  always_comb begin
    goes_after = ranks_after(64'(in_t), 64'(st_t));
    take_ev    = in_v && !occ && !shift_en;
    bump_ev    = in_v && occ && !goes_after && !shift_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= 1'b0;
      st_t  <= '0;
      st_h  <= '0;
      st_p  <= '0;
      fwd_v <= 1'b0;
      fwd_t <= '0;
      fwd_h <= '0;
      fwd_p <= '0;
    end else if (shift_en) begin
      occ   <= nxt_occ;
      st_t  <= nxt_t;
      st_h  <= nxt_h;
      st_p  <= nxt_p;
      fwd_v <= 1'b0;
    end else begin
      fwd_v <= in_v && occ;
      fwd_t <= in_t;
      fwd_h <= in_h;
      fwd_p <= POS_W'(step_pos(64'(in_p), goes_after));
      if (take_ev) begin
        occ  <= 1'b1;
        st_t <= in_t;
        st_h <= in_h;
        st_p <= in_p;
      end else if (bump_ev) begin
        st_p <= POS_W'(step_pos(64'(st_p), 1'b1));
      end
    end
  end

  // R6
  drain_before_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !in_v);

  // R7
  no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump_ev |-> (st_p < POS_W'(N_CELLS - 1)));

endmodule

// File: rtl/insort_ram.sv
module insort_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 20,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/insort_ctrl.sv
module insort_ctrl
  import insort_pkg::*;
#(
  parameter int N_CELLS = 32,
  parameter int POS_W   = $clog2(N_CELLS),
  parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             frame_end,
  input  logic             chain_busy,
  input  logic             head_occ,
  input  logic [POS_W-1:0] head_pos,
  output logic             in_ready,
  output logic             accept,
  output logic             shift_en,
  output logic             wr_en,
  output logic             rd_en,
  output logic [POS_W-1:0] rd_addr,
  output logic             out_valid,
  output logic             out_last,
  output phase_e           phase_o
);

  phase_e           ph;
  logic [CNT_W-1:0] acc_cnt;
  logic [CNT_W-1:0] unl_cnt;
  logic [POS_W-1:0] rd_ptr;
  logic             rd_is_last;

  always_comb begin
    in_ready   = (ph == PH_FILL) && (acc_cnt < CNT_W'(N_CELLS));
    accept     = in_valid && in_ready;
    shift_en   = (ph == PH_UNLOAD);
    wr_en      = (ph == PH_UNLOAD) && head_occ;
    rd_en      = (ph == PH_READ);
    rd_addr    = rd_ptr;
    rd_is_last = (CNT_W'(rd_ptr) == (unl_cnt - CNT_W'(1)));
    phase_o    = ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_FILL;
      acc_cnt   <= '0;
      unl_cnt   <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= rd_en;
      out_last  <= rd_en && rd_is_last;
      case (ph)
        PH_FILL: begin
          if (accept) acc_cnt <= acc_cnt + CNT_W'(1);
          if (frame_end) ph <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (!chain_busy) begin
            ph      <= PH_UNLOAD;
            unl_cnt <= '0;
          end
        end
        PH_UNLOAD: begin
          if (head_occ) begin
            unl_cnt <= unl_cnt + CNT_W'(1);
          end else if (unl_cnt == '0) begin
            ph      <= PH_FILL;
            acc_cnt <= '0;
          end else begin
            ph     <= PH_READ;
            rd_ptr <= '0;
          end
        end
        PH_READ: begin
          rd_ptr <= rd_ptr + POS_W'(1);
          if (rd_is_last) ph <= PH_TAIL;
        end
        PH_TAIL: begin
          ph      <= PH_FILL;
          acc_cnt <= '0;
        end
        default: ph <= PH_FILL;
      endcase
    end
  end

  // R7
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt <= CNT_W'(N_CELLS));

  // R6
  no_accept_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ph == PH_FILL) |=> !in_ready);

  // R5
  last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R5
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (CNT_W'(head_pos) < acc_cnt));

  // R5
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (CNT_W'(rd_addr) < unl_cnt));

endmodule

// File: rtl/insort_array.sv
module insort_array
  import insort_pkg::*;
#(
  parameter int N_CELLS = 32,
  parameter int TIME_W  = 16,
  parameter int HITS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TIME_W-1:0] in_time,
  input  logic [HITS_W-1:0] in_hits,
  input  logic              frame_end,
  output logic              in_ready,
  output logic              out_valid,
  output logic [TIME_W-1:0] out_time,
  output logic [HITS_W-1:0] out_hits,
  output logic              out_last
);

  localparam int POS_W  = $clog2(N_CELLS);
  localparam int CNT_W  = $clog2(N_CELLS + 1);
  localparam int DATA_W = TIME_W + HITS_W;

  // chain links: lnk[g] feeds cell g
  logic              lnk_v [N_CELLS];
  logic [TIME_W-1:0] lnk_t [N_CELLS];
  logic [HITS_W-1:0] lnk_h [N_CELLS];
  logic [POS_W-1:0]  lnk_p [N_CELLS];
  // stored contents of each cell
  logic              so_occ [N_CELLS];
  logic [TIME_W-1:0] so_t   [N_CELLS];
  logic [HITS_W-1:0] so_h   [N_CELLS];
  logic [POS_W-1:0]  so_p   [N_CELLS];

  logic [N_CELLS-1:0] ev_take;
  logic [N_CELLS-1:0] ev_bump;

  logic              tail_v;
  logic [TIME_W-1:0] unused_tail_t;
  logic [HITS_W-1:0] unused_tail_h;
  logic [POS_W-1:0]  unused_tail_p;

  logic              accept, shift_en, wr_en, rd_en, chain_busy;
  logic [POS_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;
  phase_e            phase;

  assign lnk_v[0] = accept;
  assign lnk_t[0] = in_time;
  assign lnk_h[0] = in_hits;
  assign lnk_p[0] = '0;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    logic              n_occ;
    logic [TIME_W-1:0] n_t;
    logic [HITS_W-1:0] n_h;
    logic [POS_W-1:0]  n_p;
    logic              f_v;
    logic [TIME_W-1:0] f_t;
    logic [HITS_W-1:0] f_h;
    logic [POS_W-1:0]  f_p;

    if (g == N_CELLS - 1) begin : g_end
      assign n_occ = 1'b0;
      assign n_t   = '0;
      assign n_h   = '0;
      assign n_p   = '0;
      assign tail_v        = f_v;
      assign unused_tail_t = f_t;
      assign unused_tail_h = f_h;
      assign unused_tail_p = f_p;
    end else begin : g_mid
      assign n_occ = so_occ[g+1];
      assign n_t   = so_t[g+1];
      assign n_h   = so_h[g+1];
      assign n_p   = so_p[g+1];
      assign lnk_v[g+1] = f_v;
      assign lnk_t[g+1] = f_t;
      assign lnk_h[g+1] = f_h;
      assign lnk_p[g+1] = f_p;
    end

    insort_cell #(
      .N_CELLS(N_CELLS), .TIME_W(TIME_W), .HITS_W(HITS_W), .POS_W(POS_W)
    ) cell_i (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .in_v(lnk_v[g]), .in_t(lnk_t[g]), .in_h(lnk_h[g]), .in_p(lnk_p[g]),
      .fwd_v(f_v), .fwd_t(f_t), .fwd_h(f_h), .fwd_p(f_p),
      .nxt_occ(n_occ), .nxt_t(n_t), .nxt_h(n_h), .nxt_p(n_p),
      .occ(so_occ[g]), .st_t(so_t[g]), .st_h(so_h[g]), .st_p(so_p[g]),
      .take_ev(ev_take[g]), .bump_ev(ev_bump[g])
    );
  end

  always_comb begin
    chain_busy = tail_v;
    for (int g = 1; g < N_CELLS; g++) chain_busy = chain_busy | lnk_v[g];
  end

  insort_ctrl #(.N_CELLS(N_CELLS), .POS_W(POS_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_end(frame_end),
    .chain_busy(chain_busy), .head_occ(so_occ[0]), .head_pos(so_p[0]),
    .in_ready(in_ready), .accept(accept), .shift_en(shift_en),
    .wr_en(wr_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_last(out_last), .phase_o(phase)
  );

  insort_ram #(.DEPTH(N_CELLS), .DATA_W(DATA_W), .ADDR_W(POS_W)) ram_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(so_p[0]), .wr_data({so_t[0], so_h[0]}),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign out_time = rd_data[DATA_W-1:HITS_W];
  assign out_hits = rd_data[HITS_W-1:0];

  // R2
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && !$past(out_last)) |-> (out_time >= $past(out_time)));

  // R5
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_take));

  // R6
  bump_only_gathering_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bump != '0) |-> (phase == PH_FILL || phase == PH_DRAIN));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_v);

endmodule

// File: tb/insort_array_tb_top.sv
module insort_array_tb_top;

  localparam int N  = 32;
  localparam int TW = 16;
  localparam int HW = 4;

  localparam int NFR = 4;
  localparam logic [TW-1:0] VT [NFR][8] = '{
    '{16'd300, 16'd12, 16'd4000, 16'd77, 16'd12, 16'd9, 16'd65535, 16'd0},
    '{16'd10,  16'd20, 16'd30,   16'd40, 16'd50, 16'd0, 16'd0,     16'd0},
    '{16'd90,  16'd80, 16'd70,   16'd60, 16'd50, 16'd40, 16'd0,    16'd0},
    '{16'd7,   16'd7,  16'd7,    16'd0,  16'd0,  16'd0,  16'd0,    16'd0}
  };
  localparam int VN [NFR]     = '{8, 5, 6, 3};
  localparam bit VPOKE [NFR]  = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_time = '0;
  logic [HW-1:0] in_hits = '0;
  logic          frame_end = 1'b0;
  logic          in_ready, out_valid, out_last;
  logic [TW-1:0] out_time;
  logic [HW-1:0] out_hits;

  int checks = 0;
  int fails  = 0;

  logic [TW-1:0] fr_t [64];
  logic [HW-1:0] fr_h [64];
  logic [TW-1:0] ex_t [64];
  logic [HW-1:0] ex_h [64];
  logic [TW-1:0] gt_t [64];
  logic [HW-1:0] gt_h [64];

  always #4 clk = ~clk;

  insort_array #(.N_CELLS(N), .TIME_W(TW), .HITS_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_time(in_time),
    .in_hits(in_hits), .frame_end(frame_end), .in_ready(in_ready),
    .out_valid(out_valid), .out_time(out_time), .out_hits(out_hits),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int n, input bit poke, input string treq, input string hreq);
    int acc_n, got_n, last_idx, lim;
    bit done, bad_ready;
    acc_n = (n > N) ? N : n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i < N) chk(in_ready == 1'b1, "R7 ready below capacity", in_ready, 1);
      else       chk(in_ready == 1'b0, "R7 ready low when full", in_ready, 0);
      in_valid = 1'b1;
      in_time  = fr_t[i];
      in_hits  = fr_h[i];
    end
    @(negedge clk);
    in_valid  = 1'b0;
    frame_end = 1'b1;
    // expected order: stable insertion sort of the accepted entries
    for (int i = 0; i < acc_n; i++) begin
      ex_t[i] = fr_t[i];
      ex_h[i] = fr_h[i];
    end
    for (int i = 1; i < acc_n; i++) begin
      logic [TW-1:0] kt;
      logic [HW-1:0] kh;
      int j;
      kt = ex_t[i];
      kh = ex_h[i];
      j = i - 1;
      while (j >= 0 && ex_t[j] > kt) begin
        ex_t[j+1] = ex_t[j];
        ex_h[j+1] = ex_h[j];
        j--;
      end
      ex_t[j+1] = kt;
      ex_h[j+1] = kh;
    end
    got_n = 0; last_idx = -1; done = 1'b0; bad_ready = 1'b0;
    lim = (acc_n == 0) ? 8 : 400;
    for (int c = 0; c < lim && !done; c++) begin
      @(negedge clk);
      if (in_ready) bad_ready = 1'b1;
      if (out_valid) begin
        if (got_n < 64) begin
          gt_t[got_n] = out_time;
          gt_h[got_n] = out_hits;
        end
        if (out_last) begin
          last_idx = got_n;
          done = 1'b1;
        end
        got_n++;
      end
      frame_end = 1'b0;
      if (poke && !done) begin
        in_valid = 1'b1;
        in_time  = '0;
        in_hits  = 4'hF;
      end else begin
        in_valid = 1'b0;
      end
    end
    in_valid = 1'b0;
    if (acc_n == 0) begin
      chk(got_n == 0, "R8 no beats on empty frame", got_n, 0);
      chk(in_ready == 1'b1, "R8 ready after empty frame", in_ready, 1);
    end else begin
      chk(done, "R5 last beat seen", done, 1);
      chk(got_n == acc_n, "R5 beat count", got_n, acc_n);
      chk(last_idx == acc_n - 1, "R5 last flag position", last_idx, acc_n - 1);
      chk(!bad_ready, "R6 ready low during sort", bad_ready, 0);
      for (int i = 0; i < acc_n && i < got_n; i++) begin
        chk(gt_t[i] == ex_t[i], treq, gt_t[i], ex_t[i]);
        chk(gt_h[i] == ex_h[i], hreq, gt_h[i], ex_h[i]);
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R6 ready after readout", in_ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_last == 1'b0, "R1 last after reset", out_last, 0);

    // table walk: orderings R2, ties R3, tags R4, busy pokes R6
    for (int f = 0; f < NFR; f++) begin
      for (int i = 0; i < VN[f]; i++) begin
        fr_t[i] = VT[f][i];
        fr_h[i] = HW'(i + 1);
      end
      run_frame(VN[f], VPOKE[f], (f == 3) ? "R3 equal-time order" : "R2 sorted time",
                (f == 3) ? "R3 tag order on ties" : "R4 tag follows time");
    end

    // R8 empty frame
    run_frame(0, 1'b0, "R8", "R8");

    // R7 capacity: 34 offered, 32 taken, pokes during readout (R6)
    for (int i = 0; i < 34; i++) begin
      fr_t[i] = TW'(1000 - 3 * i);
      fr_h[i] = HW'(i);
    end
    run_frame(34, 1'b1, "R7 full frame order", "R4 full frame tags");

    // R3 many ties across a full frame
    for (int i = 0; i < N; i++) begin
      fr_t[i] = TW'(i % 4);
      fr_h[i] = HW'(i);
    end
    run_frame(N, 1'b0, "R3 tie order full", "R3 tie tags full");

    // frame right after a full one still sorts (R2)
    for (int i = 0; i < 4; i++) begin
      fr_t[i] = TW'(500 - 100 * i);
      fr_h[i] = HW'(9 + i);
    end
    run_frame(4, 1'b0, "R2 back-to-back frame", "R4 back-to-back tags");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule